// File: doc/BRIEF.md
# Two-Dimensional Spike Address Transmitter

This block reads spike events out of a pixel array, one event at a time, and sends each one off-chip as a binary row and column address. A pixel with an event raises the request line of its row. The block grants one requesting row. Pixels in that row then raise their column request lines, and the block grants one of those columns. The granted row and column are encoded into a single address word, with the row field in the upper bits. After a fixed settling interval the block raises the chip request.

The off-chip link is a bundled-data four-phase handshake, not a valid/ready stream. The address must be valid before the request rises, and it is held unchanged while the request is high. The receiver applies back-pressure by delaying its acknowledge. No new event leaves while the acknowledge is high, and arbitration of the next row waits until the acknowledge has been seen low again. The acknowledge input passes through a two-flop synchronizer before the controller uses it.

Both arbiters are round-robin. After a row or column wins, its arbiter starts its next search at the index just above the winner. A busy row or column therefore cannot hold the bus while other lines are waiting.

Top module: `aer_tx_seq`

## Requirements
- R1: While reset is asserted and in the first cycle after it, all row and column acknowledges are zero, chip_req is low and addr_out is zero.
- R2: At most one row acknowledge is high at any time. It goes only to a row whose request was high when the row was chosen.
- R3: A column acknowledge is given only while a row acknowledge is held. Column requests seen while no row is granted are ignored, and the column acknowledges stay zero.
- R4: addr_out is {row index, column index}. The row field takes the upper ceil(log2 ROWS) bits and the column field the lower ceil(log2 COLS) bits. While chip_req is high, the address matches the held row and column acknowledges.
- R5: chip_req rises exactly SETUP_CYC clock cycles after the column acknowledge rises. addr_out does not change while chip_req is high.
- R6: Suppose chip_ack rises ahead of a clock edge. Then chip_req is still high after the second edge, and chip_req and all acknowledges are low after the third edge.
- R7: Suppose chip_ack falls ahead of a clock edge. Then no row acknowledge is high after the first three edges. If rows are requesting, a row acknowledge is high after the fourth edge. No row is granted while chip_ack is held high, however long that lasts.
- R8: Round-robin order. Start from reset with events at (row 0, col 0), (0, 1) and (3, 2) pending together. They leave in the order (0,0), (3,2), (0,1).
- R9: Every event a pixel raises is transmitted exactly once, with its own address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| row_req | input | ROWS | Per-row request, high while any pixel in the row has an event |
| row_ack | output | ROWS | Per-row acknowledge, one-hot or zero |
| col_req | input | COLS | Per-column request from pixels of the acknowledged row |
| col_ack | output | COLS | Per-column acknowledge, one-hot or zero |
| addr_out | output | RAW+CAW | Encoded address {row, column} |
| chip_req | output | 1 | Off-chip request, bundled with addr_out |
| chip_ack | input | 1 | Off-chip acknowledge, asynchronous |

## Verification
Three events pending at once expose the arbitration order. A design that keeps priority fixed, or that moves the pointer wrongly, sends (0,1) before (3,2). A receiver that holds its acknowledge high for a long time exposes a missing interlock: a design that re-arbitrates on the falling chip request, rather than on the synchronized acknowledge, grants a row while chip_ack is still high. Column requests driven with no row granted would make a design that leaves its column arbiter free-running produce a column acknowledge. Exact latency checks on the settling interval and on both synchronizer paths catch an off-by-one setup counter and a missing or extra flop. A sweep of every pixel shows whether events are dropped, duplicated or mis-encoded.

// File: rtl/aer_tx_pkg.sv
package aer_tx_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,   // waiting for a row request
    ST_ROW,    // row granted, waiting for a column request
    ST_SETUP,  // address latched, settling
    ST_REQ,    // chip request high
    ST_DRAIN   // waiting for acknowledge to return low
  } tx_state_e;
endpackage

// File: rtl/aer_sync2.sv
module aer_sync2 (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic meta;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta <= 1'b0;
      q    <= 1'b0;
    end else begin
      meta <= d;
      q    <= meta;
    end
  end
endmodule

// File: rtl/aer_rr_arb.sv
module aer_rr_arb #(
  parameter int N = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] req,
  input  logic         take,
  output logic [N-1:0] gnt,
  output logic         any
);
  localparam int IW = (N > 1) ? $clog2(N) : 1;

  logic [IW-1:0] ptr;
  logic [IW-1:0] win;

  // search upward from ptr, wrapping at N
  always_comb begin
    logic [IW:0] s;
    gnt = '0;
    win = '0;
    any = 1'b0;
    for (int i = 0; i < N; i++) begin
      s = {1'b0, ptr} + (IW+1)'(i);
      if (s >= (IW+1)'(N)) s = s - (IW+1)'(N);
      if (!any && req[s[IW-1:0]]) begin
        any              = 1'b1;
        gnt[s[IW-1:0]]   = 1'b1;
        win              = s[IW-1:0];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ptr <= '0;
    else if (take && any) ptr <= (win == IW'(N-1)) ? '0 : win + 1'b1;
  end
endmodule

// File: rtl/aer_enc.sv
module aer_enc #(
  parameter int M = 8,
  parameter int W = 3
) (
  input  logic [M-1:0] onehot,
  output logic [W-1:0] code
);
  always_comb begin
    code = '0;
    for (int i = 0; i < M; i++)
      if (onehot[i]) code = code | W'(i);
  end
endmodule

// File: rtl/aer_tx_seq.sv
module aer_tx_seq #(
  parameter int ROWS      = 8,
  parameter int COLS      = 8,
  parameter int SETUP_CYC = 2,
  localparam int RAW = (ROWS > 1) ? $clog2(ROWS) : 1,
  localparam int CAW = (COLS > 1) ? $clog2(COLS) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ROWS-1:0]   row_req,
  output logic [ROWS-1:0]   row_ack,
  input  logic [COLS-1:0]   col_req,
  output logic [COLS-1:0]   col_ack,
  output logic [RAW+CAW-1:0] addr_out,
  output logic              chip_req,
  input  logic              chip_ack
);
  import aer_tx_pkg::*;

  localparam int AW = RAW + CAW;
  localparam int CW = (SETUP_CYC > 1) ? $clog2(SETUP_CYC) : 1;

  tx_state_e        state;
  logic             ack_s;
  logic [ROWS-1:0]  row_gnt, row_sel_q;
  logic [COLS-1:0]  col_gnt, col_sel_q;
  logic             row_any, col_any;
  logic             row_take, col_take;
  logic [RAW-1:0]   row_code;
  logic [CAW-1:0]   col_code;
  logic [AW-1:0]    addr_q;
  logic [CW-1:0]    cnt;

  aer_sync2 u_ack_sync (.clk(clk), .rst_n(rst_n), .d(chip_ack), .q(ack_s));

  assign row_take = (state == ST_IDLE) && !ack_s && row_any;
  assign col_take = (state == ST_ROW) && col_any;

  aer_rr_arb #(.N(ROWS)) u_row_arb (
    .clk(clk), .rst_n(rst_n), .req(row_req), .take(row_take),
    .gnt(row_gnt), .any(row_any));

  aer_rr_arb #(.N(COLS)) u_col_arb (
    .clk(clk), .rst_n(rst_n), .req(col_req), .take(col_take),
    .gnt(col_gnt), .any(col_any));

  aer_enc #(.M(ROWS), .W(RAW)) u_row_enc (.onehot(row_sel_q), .code(row_code));
  aer_enc #(.M(COLS), .W(CAW)) u_col_enc (.onehot(col_gnt),   .code(col_code));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      row_sel_q <= '0;
      col_sel_q <= '0;
      addr_q    <= '0;
      cnt       <= '0;
    end else begin
      unique case (state)
        ST_IDLE: if (row_take) begin
          row_sel_q <= row_gnt;
          state     <= ST_ROW;
        end
        ST_ROW: if (col_take) begin
          col_sel_q <= col_gnt;
          addr_q    <= {row_code, col_code};
          cnt       <= '0;
          state     <= ST_SETUP;
        end
        ST_SETUP: begin
          if (cnt == CW'(SETUP_CYC - 1)) state <= ST_REQ;
          else cnt <= cnt + 1'b1;
        end
        ST_REQ: if (ack_s) begin
          row_sel_q <= '0;
          col_sel_q <= '0;
          state     <= ST_DRAIN;
        end
        ST_DRAIN: if (!ack_s) state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign row_ack  = (state == ST_ROW || state == ST_SETUP || state == ST_REQ) ? row_sel_q : '0;
  assign col_ack  = (state == ST_SETUP || state == ST_REQ) ? col_sel_q : '0;
  assign chip_req = (state == ST_REQ);
  assign addr_out = addr_q;
endmodule

// File: rtl/aer_tx_seq_chk.sv
module aer_tx_seq_chk #(
  parameter int ROWS      = 8,
  parameter int COLS      = 8,
  parameter int SETUP_CYC = 2,
  localparam int RAW = (ROWS > 1) ? $clog2(ROWS) : 1,
  localparam int CAW = (COLS > 1) ? $clog2(COLS) : 1
) (
  input logic               clk,
  input logic               rst_n,
  input logic [ROWS-1:0]    row_ack,
  input logic [COLS-1:0]    col_ack,
  input logic [RAW+CAW-1:0] addr_out,
  input logic               chip_req,
  input logic               ack_s
);
  localparam int SW = $clog2(SETUP_CYC + 2) + 1;
  logic [SW-1:0] held;

  // cycles the column acknowledge has been high, saturating
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) held <= '0;
    else if (col_ack == '0) held <= '0;
    else if (held < SW'(SETUP_CYC + 1)) held <= held + 1'b1;
  end

  assert_row_onehot_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(row_ack));
  assert_col_onehot_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(col_ack));
  assert_col_in_row_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (col_ack != '0) |-> (row_ack != '0));
  assert_addr_match_R4: assert property (@(posedge clk) disable iff (!rst_n)
    chip_req |-> row_ack[addr_out[RAW+CAW-1:CAW]] && col_ack[addr_out[CAW-1:0]]);
  assert_setup_wait_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(chip_req) |-> (held >= SW'(SETUP_CYC)));
  assert_addr_stable_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (chip_req && $past(chip_req)) |-> $stable(addr_out));
  assert_req_has_col_R6: assert property (@(posedge clk) disable iff (!rst_n)
    chip_req |-> (col_ack != '0));
  assert_no_row_in_ack_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(row_ack) == '0 && row_ack != '0) |-> (!ack_s && !chip_req));
endmodule

bind aer_tx_seq aer_tx_seq_chk #(.ROWS(ROWS), .COLS(COLS), .SETUP_CYC(SETUP_CYC)) u_chk (
  .clk(clk), .rst_n(rst_n), .row_ack(row_ack), .col_ack(col_ack),
  .addr_out(addr_out), .chip_req(chip_req), .ack_s(ack_s));

// File: tb/aer_tx_seq_bench.sv
module aer_tx_seq_bench;
  localparam int ROWS = 6;
  localparam int COLS = 5;
  localparam int SETUP = 2;
  localparam int RAW = 3;
  localparam int CAW = 3;
  localparam int AW = RAW + CAW;

  logic clk = 1'b0;
  logic rst_n;
  logic [ROWS-1:0] row_req, row_ack;
  logic [COLS-1:0] col_req, col_ack, spur_col;
  logic [AW-1:0]   addr_out;
  logic chip_req, chip_ack;

  bit pend [ROWS][COLS];
  int expcnt [ROWS][COLS];
  int ordq [$];
  int errors = 0, checks = 0;
  int rel_dly = 0;
  int setup_cnt = 0;
  bit req_prev = 1'b0;
  bit done = 1'b0;
  logic [AW-1:0] held_addr;

  always #2 clk = ~clk;

  aer_tx_seq #(.ROWS(ROWS), .COLS(COLS), .SETUP_CYC(SETUP)) u_aer_tx_seq (
    .clk(clk), .rst_n(rst_n), .row_req(row_req), .row_ack(row_ack),
    .col_req(col_req), .col_ack(col_ack), .addr_out(addr_out),
    .chip_req(chip_req), .chip_ack(chip_ack));

  // pixel array model
  always_comb begin
    row_req = '0;
    col_req = spur_col;
    for (int r = 0; r < ROWS; r++)
      for (int c = 0; c < COLS; c++) begin
        if (pend[r][c]) row_req[r] = 1'b1;
        if (pend[r][c] && row_ack[r]) col_req[c] = 1'b1;
      end
  end

  always @(negedge clk)
    for (int r = 0; r < ROWS; r++)
      for (int c = 0; c < COLS; c++)
        if (pend[r][c] && row_ack[r] && col_ack[c]) pend[r][c] = 1'b0;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic int enc(input int r, input int c);
    return r * (1 << CAW) + c;
  endfunction

  function automatic int outstanding();
    int t = 0;
    for (int r = 0; r < ROWS; r++)
      for (int c = 0; c < COLS; c++) t += expcnt[r][c];
    return t;
  endfunction

  task automatic inject(input int r, input int c);
    pend[r][c] = 1'b1;
    expcnt[r][c]++;
  endtask

  task automatic drain();
    do @(negedge clk);
    while (outstanding() != 0 || chip_req || chip_ack || row_ack != '0);
    repeat (6) @(negedge clk);
  endtask

  // monitor / scoreboard
  always @(negedge clk) begin
    if (rst_n) begin
      if (chip_req && !req_prev) begin
        int r, c;
        r = int'(addr_out[AW-1:CAW]);
        c = int'(addr_out[CAW-1:0]);
        held_addr = addr_out;
        if (r < ROWS && c < COLS) begin
          chk(expcnt[r][c] > 0, "R9", "event sent once", expcnt[r][c], 1);
          if (expcnt[r][c] > 0) expcnt[r][c]--;
          chk(row_ack == ROWS'(1 << r), "R4", "row field vs row_ack", int'(row_ack), 1 << r);
          chk(col_ack == COLS'(1 << c), "R4", "col field vs col_ack", int'(col_ack), 1 << c);
        end else
          chk(1'b0, "R4", "address in range", int'(addr_out), 0);
        chk(setup_cnt == SETUP, "R5", "setup cycles", setup_cnt, SETUP);
        if (ordq.size() > 0) begin
          int e;
          e = ordq.pop_front();
          chk(int'(addr_out) == e, "R8", "round-robin order", int'(addr_out), e);
        end
      end else if (chip_req && req_prev) begin
        if (addr_out != held_addr)
          chk(1'b0, "R5", "address stable under request", int'(addr_out), int'(held_addr));
      end
      if (col_ack == '0) setup_cnt = 0;
      else if (!chip_req) setup_cnt++;
      req_prev = chip_req;
    end
  end

  // off-chip receiver model
  initial begin
    chip_ack = 1'b0;
    forever begin
      @(negedge clk);
      if (rst_n && chip_req && !chip_ack) begin
        bit had;
        logic [ROWS-1:0] rq;
        @(negedge clk);
        chip_ack = 1'b1;
        @(negedge clk); @(negedge clk);
        chk(chip_req == 1'b1, "R6", "request held two edges after ack", int'(chip_req), 1);
        @(negedge clk);
        chk(!chip_req && row_ack == '0 && col_ack == '0, "R6",
            "release on third edge", int'(chip_req) + int'(row_ack) + int'(col_ack), 0);
        for (int k = 0; k < rel_dly; k++) begin
          @(negedge clk);
          chk(row_ack == '0, "R7", "no grant while ack high", int'(row_ack), 0);
        end
        chip_ack = 1'b0;
        for (int k = 0; k < 3; k++) begin
          @(negedge clk);
          chk(row_ack == '0, "R7", "no grant before ack sync low", int'(row_ack), 0);
        end
        had = (row_req != '0);
        rq = row_req;
        @(negedge clk);
        if (had) begin
          chk(row_ack != '0, "R7", "grant on fourth edge", int'(row_ack), 1);
          chk((row_ack & ~rq) == '0, "R2", "grant to requesting row", int'(row_ack), int'(rq));
        end
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    spur_col = '0;
    repeat (4) @(negedge clk);
    chk(row_ack == '0 && col_ack == '0 && !chip_req && addr_out == '0, "R1",
        "state in reset", int'(row_ack) + int'(col_ack) + int'(chip_req) + int'(addr_out), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(row_ack == '0 && col_ack == '0 && !chip_req && addr_out == '0, "R1",
        "state after reset", int'(row_ack) + int'(col_ack) + int'(chip_req) + int'(addr_out), 0);

    // R8: fairness order from reset
    ordq.push_back(enc(0, 0));
    ordq.push_back(enc(3, 2));
    ordq.push_back(enc(0, 1));
    inject(0, 0); inject(0, 1); inject(3, 2);
    drain();
    chk(ordq.size() == 0, "R8", "all ordered events seen", ordq.size(), 0);

    // R4: single event at the top column index
    ordq.push_back(enc(2, 4));
    inject(2, 4);
    drain();

    // R3: stray column requests with no row granted
    spur_col = '1;
    for (int k = 0; k < 12; k++) begin
      @(negedge clk);
      chk(col_ack == '0 && row_ack == '0 && !chip_req, "R3",
          "stray column request ignored", int'(col_ack), 0);
    end
    spur_col = '0;
    repeat (2) @(negedge clk);

    // R7: receiver holds acknowledge for a long time
    rel_dly = 15;
    inject(5, 4); inject(1, 0);
    drain();
    rel_dly = 0;

    // R9: every pixel once
    for (int r = 0; r < ROWS; r++)
      for (int c = 0; c < COLS; c++) inject(r, c);
    drain();
    chk(outstanding() == 0, "R9", "nothing left unsent", outstanding(), 0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule